// File: doc/BRIEF.md
# Password-Protected Watchdog Timer

This block is a watchdog timer behind a small 32-bit register port. Software arms the timer, chooses a tick rate and a warning level, and sets a 16-bit reload value. Once running, the counter steps down by one on every prescaled tick. It raises a level warning when the count has fallen to a chosen fraction of the full range. When the count reaches zero it pulses a one-cycle reset request. Software keeps the system alive by writing the reload value again before the count runs out.

The control register cannot be changed by a single write. A write to the control offset whose key byte (bits 23:16) is 0xBE only opens the lock. The next write to the block must go to the control offset and carry the key byte 0xDC. Only that write updates the control fields. Any other write in between, or a wrong key, closes the lock again and changes nothing. A sticky expiry flag records that the watchdog fired. The flag survives the system reset input and is cleared only by the power-on reset.

Top module: `pw_watchdog`

## Requirements
- R1: After power-on reset, reads of offsets 0x0, 0x8 and 0xC all return 0, and both warnOut and rstReq are low.
- R2: A write to offset 0x0 with key byte 0xBE in bits 23:16 only opens the lock. The control readback, the status and the outputs stay unchanged, whatever the other bits of that write hold.
- R3: A write to offset 0x0 with key 0xDC that directly follows an opening write loads the control fields: enable in bit 31, warning select in bits 27:26, prescaler select in bits 25:24 and reload in bits 15:0. Reading offset 0x0 returns these fields in the same positions, with every other bit reading 0.
- R4: A key-0xDC write with no opening write directly before it, a write to offset 0x0 with any key other than 0xBE or 0xDC, and a write to any other offset between the opening write and the key-0xDC write all leave the control fields unchanged. Each of these also closes the lock.
- R5: Reading offset 0x8 returns the enable state in bit 31 and the live count in bits 15:0. A committing write with enable set loads the count with the reload value, and the count then drops by one per prescaled tick.
- R6: Prescaler select values 0, 1, 2 and 3 give one tick every 1, 64, 4096 and 262144 clock cycles. The prescaler restarts from zero on every committing write.
- R7: warnOut is high while the timer is enabled and the count is at or below the threshold that the warning select picks: 0x8000, 0x4000, 0x2000 or 0x1000 for select 0, 1, 2 or 3.
- R8: The tick that takes the count from 1 to 0, or the first tick when the count is already 0, produces exactly one rstReq pulse of one clock cycle. After that the count stays at 0, and no further pulse comes until the next committing write.
- R9: Expiry sets a flag that reads as bit 31 of offset 0xC. The flag is kept through sysRstN and cleared only by porN.
- R10: A committing write made while the timer runs reloads the count and restarts the prescaler. A restart made before expiry produces no rstReq.
- R11: A committing write with enable clear stops the timer. Status bit 31 reads 0, the count holds its value, and warnOut drops.
- R12: Read data appears on rdData one clock after rdEn. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| sysRstN | input | 1 | System reset, active low, asynchronous; clears everything except the expiry flag |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data, valid the cycle after rdEn |
| warnOut | output | 1 | Level pre-warning |
| rstReq | output | 1 | One-cycle reset request at expiry |

## Verification
The hardest cases to reach from the ports are the lock rejections. These are a lone commit, a wrong key, and an opening write followed by a stray write to the status offset. In each one the visible control state must stay unchanged. The stimulus chains these writes back to back and reads the control register after each chain. A plain key-0xDC write then shows that the lock really closed. Expiry under the slower prescaler settings depends on exact cycle counts. The bench records the edge at which each commit is taken. From that edge it predicts the count at every read and the edge at which the pulse must appear.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam int CNT_W = 16;
  localparam int DATA_W = 32;
  localparam logic [7:0] KEY_OPEN = 8'hBE;
  localparam logic [7:0] KEY_COMMIT = 8'hDC;

  // bit positions the register layout depends on
  localparam int EN_BIT = 31;
  localparam int WSEL_LO = 26;
  localparam int DSEL_LO = 24;
  localparam int KEY_LO = 16;

  typedef enum logic {
    LK_CLOSED = 1'b0,
    LK_OPEN   = 1'b1
  } lockSt_t;

  typedef struct packed {
    logic             load;
    logic             startEn;
    logic [CNT_W-1:0] reload;
    logic [1:0]       divSel;
    logic [1:0]       warnSel;
  } ctlStrb_t;

  function automatic int maxField(logic [19:0] tbl);
    int m;
    m = 1;
    for (int i = 0; i < 4; i++) begin
      if (int'(tbl[i*5 +: 5]) > m) m = int'(tbl[i*5 +: 5]);
    end
    return m;
  endfunction

endpackage

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CTRL_OFS = 0,
  parameter int STAT_OFS = 8,
  parameter int CAUSE_OFS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              cause,
  output ctlStrb_t          strb,
  output logic              runFlag,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(CAUSE_OFS);

  lockSt_t lockSt;
  logic cfgEn;
  logic [1:0] cfgWarn;
  logic [1:0] cfgDiv;
  logic [CNT_W-1:0] cfgReload;

  logic isCtrl;
  logic [7:0] keyByte;
  logic openHit;
  logic commitHit;
  logic [DATA_W-1:0] rdMux;

  always_comb begin
    isCtrl = (addr == A_CTRL);
    keyByte = wrData[KEY_LO +: 8];
    openHit = wrEn && isCtrl && (keyByte == KEY_OPEN);
    commitHit = wrEn && isCtrl && (keyByte == KEY_COMMIT) && (lockSt == LK_OPEN);
  end

  // lock: only writes move it; a read leaves it alone
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockSt <= LK_CLOSED;
    end else if (wrEn) begin
      lockSt <= openHit ? LK_OPEN : LK_CLOSED;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEn <= 1'b0;
      cfgWarn <= '0;
      cfgDiv <= '0;
      cfgReload <= '0;
    end else if (commitHit) begin
      cfgEn <= wrData[EN_BIT];
      cfgWarn <= wrData[WSEL_LO +: 2];
      cfgDiv <= wrData[DSEL_LO +: 2];
      cfgReload <= wrData[CNT_W-1:0];
    end
  end

  always_comb begin
    strb.load = commitHit;
    strb.startEn = wrData[EN_BIT];
    strb.reload = wrData[CNT_W-1:0];
    strb.divSel = cfgDiv;
    strb.warnSel = cfgWarn;
    runFlag = cfgEn;
  end

  always_comb begin
    rdMux = '0;
    if (addr == A_CTRL) begin
      rdMux[EN_BIT] = cfgEn;
      rdMux[WSEL_LO +: 2] = cfgWarn;
      rdMux[DSEL_LO +: 2] = cfgDiv;
      rdMux[CNT_W-1:0] = cfgReload;
    end else if (addr == A_STAT) begin
      rdMux[EN_BIT] = cfgEn;
      rdMux[CNT_W-1:0] = cnt;
    end else if (addr == A_CAUSE) begin
      rdMux[EN_BIT] = cause;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else begin
      rdData <= rdEn ? rdMux : '0;
    end
  end

  p_open_keeps_cfg_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isCtrl && keyByte == KEY_OPEN)
      |=> ($stable({cfgEn, cfgWarn, cfgDiv, cfgReload}) && lockSt == LK_OPEN));

  p_reject_keeps_cfg_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !(isCtrl && keyByte == KEY_COMMIT && lockSt == LK_OPEN))
      |=> $stable({cfgEn, cfgWarn, cfgDiv, cfgReload}));

  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr != A_CTRL && addr != A_STAT && addr != A_CAUSE) |=> (rdData == '0));

endmodule

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter logic [19:0] DIV_LOG2 = {5'd18, 5'd12, 5'd6, 5'd0}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             porN,
  input  ctlStrb_t         strb,
  output logic [CNT_W-1:0] cnt,
  output logic             active,
  output logic             cause,
  output logic             warnOut,
  output logic             rstReq
);

  localparam int PS_W = maxField(DIV_LOG2);

  logic [PS_W-1:0] maskTbl [4];
  logic [CNT_W-1:0] thrTbl [4];
  logic [PS_W-1:0] presc;
  logic tick;
  logic fired;
  logic fireNow;

  for (genvar g = 0; g < 4; g++) begin : g_sel
    localparam int LG = int'(DIV_LOG2[g*5 +: 5]);
    assign maskTbl[g] = PS_W'((64'd1 << LG) - 64'd1);
    assign thrTbl[g] = CNT_W'(64'd1 << (CNT_W - 1 - g));
  end

  always_comb begin
    tick = active && !strb.load && (presc == maskTbl[strb.divSel]);
    fireNow = tick && !fired && (cnt <= CNT_W'(1));
    warnOut = active && (cnt <= thrTbl[strb.warnSel]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc <= '0;
    end else if (strb.load) begin
      presc <= '0;
    end else if (active) begin
      presc <= (presc == maskTbl[strb.divSel]) ? '0 : presc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      active <= 1'b0;
      fired <= 1'b0;
      rstReq <= 1'b0;
    end else begin
      rstReq <= fireNow;
      if (strb.load) begin
        active <= strb.startEn;
        fired <= 1'b0;
        if (strb.startEn) cnt <= strb.reload;
      end else begin
        if (fireNow) fired <= 1'b1;
        if (tick && cnt != '0) cnt <= cnt - 1'b1;
      end
    end
  end

  // expiry flag lives on the power-on reset only
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      cause <= 1'b0;
    end else if (fireNow) begin
      cause <= 1'b1;
    end
  end

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  p_count_no_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> (cnt <= $past(cnt)));

  p_halt_frozen_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !strb.load) |=> $stable(cnt));

  p_cause_sticky_r9: assert property (@(posedge clk) disable iff (!porN)
    cause |=> cause);

endmodule

// File: rtl/pw_watchdog.sv
module pw_watchdog
  import wdg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CTRL_OFS = 0,
  parameter int STAT_OFS = 8,
  parameter int CAUSE_OFS = 12,
  parameter logic [19:0] DIV_LOG2 = {5'd18, 5'd12, 5'd6, 5'd0}
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              sysRstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              warnOut,
  output logic              rstReq
);

  logic coreRstN;
  ctlStrb_t strb;
  logic [CNT_W-1:0] cnt;
  logic active;
  logic cause;
  logic runFlag;

  assign coreRstN = porN & sysRstN;

  wdg_ctrl #(
    .ADDR_W(ADDR_W),
    .CTRL_OFS(CTRL_OFS),
    .STAT_OFS(STAT_OFS),
    .CAUSE_OFS(CAUSE_OFS)
  ) i_ctrl (
    .clk(clk),
    .rstN(coreRstN),
    .wrEn(wrEn),
    .rdEn(rdEn),
    .addr(addr),
    .wrData(wrData),
    .cnt(cnt),
    .cause(cause),
    .strb(strb),
    .runFlag(runFlag),
    .rdData(rdData)
  );

  wdg_datapath #(
    .DIV_LOG2(DIV_LOG2)
  ) i_dp (
    .clk(clk),
    .rstN(coreRstN),
    .porN(porN),
    .strb(strb),
    .cnt(cnt),
    .active(active),
    .cause(cause),
    .warnOut(warnOut),
    .rstReq(rstReq)
  );

  p_run_agree_r11: assert property (@(posedge clk) disable iff (!coreRstN)
    runFlag == active);

  p_warn_needs_run_r7: assert property (@(posedge clk) disable iff (!coreRstN)
    warnOut |-> runFlag);

endmodule

// File: tb/test_pw_watchdog.sv
module test_pw_watchdog;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic sysRstN = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic warnOut;
  logic rstReq;

  pw_watchdog i_pw_watchdog (
    .clk(clk), .porN(porN), .sysRstN(sysRstN), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .warnOut(warnOut), .rstReq(rstReq)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [31:0] val;
    string tag;
  } expItem_t;

  expItem_t sbq[$];
  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;
  int pulseCnt = 0;
  int lastWrEdge = 0;
  logic rdPipe = 1'b0;
  bit done = 1'b0;

  // model of the counter, built from the requirements
  int mR = 0, mD = 1, mE0 = 0, mFrozen = 0;
  bit mRun = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rdPipe <= rdEn;
  end

  always @(negedge clk) if (rstReq) pulseCnt <= pulseCnt + 1;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per completed read
  always @(negedge clk) begin
    if (rdPipe) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R12 unexpected read data", rdData, 32'h0);
      end else begin
        expItem_t it;
        it = sbq.pop_front();
        chk(rdData == it.val, it.tag, rdData, it.val);
      end
    end
  end

  function automatic logic [31:0] expStat(int e);
    int n, c;
    if (mRun) begin
      n = (e - mE0) / mD;
      c = (n >= mR) ? 0 : mR - n;
      return {1'b1, 15'b0, 16'(c)};
    end
    return {16'b0, 16'(mFrozen)};
  endfunction

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    lastWrEdge = cyc + 1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    expItem_t it;
    it.val = exp; it.tag = tag;
    sbq.push_back(it);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic commit(logic en, logic [1:0] ws, logic [1:0] ds, logic [15:0] rl);
    int e;
    wr(4'h0, 32'h00BE0000);
    wr(4'h0, {en, 3'b0, ws, ds, 8'hDC, rl});
    e = lastWrEdge;
    if (en) begin
      mR = int'(rl); mE0 = e; mRun = 1'b1;
      mD = (ds == 2'd0) ? 1 : (ds == 2'd1) ? 64 : (ds == 2'd2) ? 4096 : 262144;
    end else begin
      mFrozen = int'(expStat(e - 1) & 32'hFFFF);
      mRun = 1'b0;
    end
  endtask

  task automatic waitTo(int e);
    while (cyc < e) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int e0;
    repeat (3) @(negedge clk);
    porN = 1'b1; sysRstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(warnOut == 1'b0, "R1 warn after reset", 32'(warnOut), 0);
    chk(rstReq == 1'b0, "R1 rstReq after reset", 32'(rstReq), 0);
    rd(4'h0, 32'h0, "R1 ctrl reset");
    rd(4'h8, 32'h0, "R1 status reset");
    rd(4'hC, 32'h0, "R1 cause reset");

    // R2: open only
    wr(4'h0, 32'h8FBE1234);
    rd(4'h0, 32'h0, "R2 ctrl after open");
    rd(4'h8, 32'h0, "R2 status after open");
    chk(warnOut == 1'b0, "R2 warn after open", 32'(warnOut), 0);

    // R4: rejections; a lone commit right after the read above finds the lock open
    // only if reads held it open, which they do, so close it first with a stray write
    wr(4'h4, 32'h0);
    wr(4'h0, 32'h8FDC0010);
    rd(4'h0, 32'h0, "R4 lone commit");
    wr(4'h0, 32'h00BE0000);
    wr(4'h0, 32'h8FAA0010);
    rd(4'h0, 32'h0, "R4 wrong key");
    wr(4'h0, 32'h00BE0000);
    wr(4'h8, 32'h8FDC0010);
    wr(4'h0, 32'h8FDC0010);
    rd(4'h0, 32'h0, "R4 stray write between");
    wr(4'h0, 32'h8FDC0010);
    rd(4'h0, 32'h0, "R4 lock closed after reject");

    // R3, R5, R8: run to expiry with prescaler 1
    commit(1'b1, 2'd3, 2'd0, 16'h0030);
    e0 = mE0;
    chk(warnOut == 1'b1, "R7 warn low count", 32'(warnOut), 1);
    rd(4'h0, 32'h8C000030, "R3 ctrl readback");
    rd(4'h8, expStat(cyc), "R5 status counting");
    rd(4'h8, expStat(cyc), "R5 status decrement");
    waitTo(e0 + 16'h30 - 1);
    chk(rstReq == 1'b0, "R8 no pulse early", 32'(rstReq), 0);
    @(negedge clk);
    chk(rstReq == 1'b1, "R8 pulse at zero", 32'(rstReq), 1);
    @(negedge clk);
    chk(rstReq == 1'b0, "R8 pulse one cycle", 32'(rstReq), 0);
    waitTo(e0 + 16'h30 + 40);
    chk(pulseCnt == 1, "R8 single pulse", 32'(pulseCnt), 1);
    rd(4'h8, 32'h80000000, "R8 count held at zero");
    rd(4'hC, 32'h80000000, "R9 cause set");

    // R10: keep-alive
    commit(1'b1, 2'd3, 2'd0, 16'h1005);
    e0 = mE0;
    chk(warnOut == 1'b0, "R7 warn above threshold", 32'(warnOut), 0);
    waitTo(e0 + 4);
    chk(warnOut == 1'b0, "R7 warn at 0x1001", 32'(warnOut), 0);
    waitTo(e0 + 5);
    chk(warnOut == 1'b1, "R7 warn at 0x1000", 32'(warnOut), 1);
    waitTo(e0 + 8);
    commit(1'b1, 2'd3, 2'd0, 16'h1005);
    chk(warnOut == 1'b0, "R10 warn clears on restart", 32'(warnOut), 0);
    rd(4'h8, expStat(cyc), "R10 count restarted");
    waitTo(mE0 + 30);
    chk(pulseCnt == 1, "R10 no pulse on restart", 32'(pulseCnt), 1);

    // R11: stop
    commit(1'b1, 2'd3, 2'd0, 16'h0F00);
    chk(warnOut == 1'b1, "R11 warn before stop", 32'(warnOut), 1);
    commit(1'b0, 2'd0, 2'd0, 16'h0777);
    chk(warnOut == 1'b0, "R11 warn after stop", 32'(warnOut), 0);
    rd(4'h8, expStat(cyc), "R11 status stopped");
    repeat (30) @(negedge clk);
    rd(4'h8, expStat(cyc), "R11 count frozen");
    rd(4'h0, 32'h00000777, "R11 ctrl readback");

    // R6: divide by 64
    commit(1'b1, 2'd0, 2'd1, 16'd3);
    e0 = mE0;
    waitTo(e0 + 63);
    rd(4'h8, expStat(cyc), "R6 div64 before tick");
    rd(4'h8, expStat(cyc), "R6 div64 after tick");
    waitTo(e0 + 191);
    chk(rstReq == 1'b0, "R6 div64 no early pulse", 32'(rstReq), 0);
    @(negedge clk);
    chk(rstReq == 1'b1, "R6 div64 pulse", 32'(rstReq), 1);

    // R6: divide by 4096
    commit(1'b1, 2'd0, 2'd2, 16'd2);
    e0 = mE0;
    waitTo(e0 + 4095);
    rd(4'h8, expStat(cyc), "R6 div4096 before tick");
    rd(4'h8, expStat(cyc), "R6 div4096 after tick");
    waitTo(e0 + 8191);
    chk(rstReq == 1'b0, "R6 div4096 no early pulse", 32'(rstReq), 0);
    @(negedge clk);
    chk(rstReq == 1'b1, "R6 div4096 pulse", 32'(rstReq), 1);

    // R7: other thresholds
    commit(1'b1, 2'd0, 2'd0, 16'h8002);
    e0 = mE0;
    waitTo(e0 + 1);
    chk(warnOut == 1'b0, "R7 sel0 above", 32'(warnOut), 0);
    waitTo(e0 + 2);
    chk(warnOut == 1'b1, "R7 sel0 at 0x8000", 32'(warnOut), 1);
    commit(1'b1, 2'd1, 2'd0, 16'h4001);
    chk(warnOut == 1'b0, "R7 sel1 above", 32'(warnOut), 0);
    waitTo(mE0 + 1);
    chk(warnOut == 1'b1, "R7 sel1 at 0x4000", 32'(warnOut), 1);
    commit(1'b1, 2'd2, 2'd0, 16'h2001);
    chk(warnOut == 1'b0, "R7 sel2 above", 32'(warnOut), 0);
    waitTo(mE0 + 1);
    chk(warnOut == 1'b1, "R7 sel2 at 0x2000", 32'(warnOut), 1);

    // R12: unmapped
    rd(4'h0, 32'h88002001, "R12 ctrl before unmapped");
    rd(4'h4, 32'h0, "R12 unmapped 0x4");
    rd(4'h2, 32'h0, "R12 unmapped 0x2");

    // R9: system reset keeps the flag, power-on reset clears it
    sysRstN = 1'b0;
    repeat (2) @(negedge clk);
    sysRstN = 1'b1;
    mRun = 1'b0; mFrozen = 0;
    @(negedge clk);
    rd(4'hC, 32'h80000000, "R9 cause kept over sysRstN");
    rd(4'h0, 32'h0, "R9 ctrl cleared by sysRstN");
    rd(4'h8, 32'h0, "R9 status cleared by sysRstN");
    porN = 1'b0;
    repeat (2) @(negedge clk);
    porN = 1'b1;
    @(negedge clk);
    rd(4'hC, 32'h0, "R9 cause cleared by porN");

    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R12 all reads returned", 32'(sbq.size()), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule